// File: doc/BRIEF.md
# Floating-point to signed 32-bit integer truncating converter

This block takes one operand in an unpacked floating-point form (a class code, a sign, an unbiased two's-complement exponent, a wide mantissa whose top bit weighs 2^exponent, and an incoming sticky bit) and turns it into a signed 32-bit integer. The conversion always truncates toward zero. No rounding mode is applied. Values outside the 32-bit range, and operands that are not numbers, saturate to the extreme integer on the operand's side.

Each accepted operand produces a registered result one clock later. Alongside the result come two per-operation flags: inexact, for discarded fraction, and operand error, for an unrepresentable operand. Both flags are also ORed into a status pair that keeps its bits until a synchronous clear. The block is meant to sit at the tail of a floating-point datapath, on the integer-store path.

Top module: `f2i_trunc`

## Requirements
- R1: With class code 0 (zero), the result is 0 with inexact and operand error both low, whatever the sign.
- R2: With class code 1 (number) and an exponent from 0 to 31, the magnitude is the mantissa shifted right by MANT_W-1-exponent, with the shifted-out bits discarded. The result is that magnitude, two's-complement negated when the sign is 1.
- R3: A number with a negative exponent gives result 0 and never raises operand error. No underflow indication exists.
- R4: For a number that does not overflow, inexact is high exactly when a discarded mantissa bit or the incoming sticky bit is 1.
- R5: A number with an exponent of 32 or more is an overflow.
- R6: A number whose truncated magnitude is at least 0x80000000 plus the sign bit is an overflow. A magnitude of exactly 0x80000000 is therefore legal only when the sign is 1, and then gives 0x80000000.
- R7: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are all overflows.
- R8: On overflow, operand error is high and inexact is low. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R9: The result and flags appear on the clock edge after in_valid is sampled high, together with out_valid. A cycle with in_valid low drops out_valid and leaves the result and flags unchanged.
- R10: The two status bits OR in the per-operation flags of every accepted operand. Only flag_clr, or reset, clears them. When flag_clr and an operand arrive in the same cycle, the status afterwards holds just that operand's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa; bit MANT_W-1 weighs 2^in_exp |
| in_sticky | input | 1 | Nonzero bits already lost below the mantissa |
| flag_clr | input | 1 | Synchronous clear of the status bits |
| out_valid | output | 1 | Result registered from an operand |
| out_result | output | 32 | Signed integer result |
| out_inexact | output | 1 | Fraction discarded by this operation |
| out_operr | output | 1 | Operand could not be represented |
| stat_inexact | output | 1 | Accumulated inexact |
| stat_operr | output | 1 | Accumulated operand error |

## Verification
The assertions assume that the inputs are settled whenever in_valid is sampled. They also assume that the exponent is a true two's-complement value, so that its top bit marks a negative exponent. They do not assume a normalized mantissa. The bench therefore drives mantissas with and without the top bit set. It covers every class code, including the unused ones. Exponents run from below zero to above 31, and it aims directed operands at the 0x80000000 boundary from both signs.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int INT_W = 32;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } f2i_class_e;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inx;
        logic             oper;
        logic             st_inx;
        logic             st_oper;
    } f2i_state_t;

endpackage

// File: rtl/f2i_align.sv
// Right-aligns the integer part of the mantissa into a 32-bit magnitude and
// reports whether any discarded bit was set.
module f2i_align #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16
) (
    input  logic [EXP_W-1:0]        exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    output logic [f2i_pkg::INT_W-1:0] mag_o,
    output logic                    frac_nz_o,
    output logic                    big_o
);
    import f2i_pkg::*;

    localparam int SH_W = $clog2(MANT_W + 1);

    logic              neg_exp;
    logic [SH_W-1:0]   shift;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] keep_mask;

    always_comb begin
        neg_exp   = exp_i[EXP_W-1];
        big_o     = !neg_exp && (exp_i[EXP_W-2:5] != '0);
        shift     = SH_W'(MANT_W - 1) - SH_W'(exp_i[4:0]);
        shifted   = mant_i >> shift;
        keep_mask = {MANT_W{1'b1}} << shift;
        mag_o     = '0;
        frac_nz_o = 1'b0;
        if (neg_exp) begin
            frac_nz_o = |mant_i;
        end else if (!big_o) begin
            mag_o     = shifted[INT_W-1:0];
            frac_nz_o = |(mant_i & ~keep_mask);
        end
    end

endmodule

// File: rtl/f2i_judge.sv
// Decides overflow from class, exponent and magnitude; forms the signed
// result and the two per-operation flags.
module f2i_judge (
    input  logic [2:0]                cls_i,
    input  logic                      sign_i,
    input  logic                      big_i,
    input  logic [f2i_pkg::INT_W-1:0] mag_i,
    input  logic                      frac_nz_i,
    input  logic                      sticky_i,
    output logic [f2i_pkg::INT_W-1:0] res_o,
    output logic                      inx_o,
    output logic                      oper_o
);
    import f2i_pkg::*;

    logic [INT_W:0] limit;
    logic           ovf;

    always_comb begin
        limit  = {1'b0, 1'b1, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, sign_i};
        ovf    = 1'b0;
        res_o  = '0;
        inx_o  = 1'b0;
        oper_o = 1'b0;
        case (f2i_class_e'(cls_i))
            CLS_ZERO: ovf = 1'b0;
            CLS_NUM: begin
                ovf   = big_i || ({1'b0, mag_i} >= limit);
                res_o = sign_i ? INT_W'(0 - mag_i) : mag_i;
                inx_o = frac_nz_i || sticky_i;
            end
            default: ovf = 1'b1;
        endcase
        if (ovf) begin
            inx_o  = 1'b0;
            oper_o = 1'b1;
            res_o  = sign_i ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
        end
    end

endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [31:0]       out_result,
    output logic              out_inexact,
    output logic              out_operr,
    output logic              stat_inexact,
    output logic              stat_operr
);
    import f2i_pkg::*;

    logic [INT_W-1:0] mag;
    logic             frac_nz;
    logic             big;
    logic [INT_W-1:0] res_c;
    logic             inx_c;
    logic             oper_c;
    f2i_state_t       st_d, st_q;

    f2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .exp_i     (in_exp),
        .mant_i    (in_mant),
        .mag_o     (mag),
        .frac_nz_o (frac_nz),
        .big_o     (big)
    );

    f2i_judge u_judge (
        .cls_i     (in_class),
        .sign_i    (in_sign),
        .big_i     (big),
        .mag_i     (mag),
        .frac_nz_i (frac_nz),
        .sticky_i  (in_sticky),
        .res_o     (res_c),
        .inx_o     (inx_c),
        .oper_o    (oper_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (flag_clr) begin
            st_d.st_inx  = 1'b0;
            st_d.st_oper = 1'b0;
        end
        if (in_valid) begin
            st_d.res     = res_c;
            st_d.inx     = inx_c;
            st_d.oper    = oper_c;
            st_d.st_inx  = st_d.st_inx  | inx_c;
            st_d.st_oper = st_d.st_oper | oper_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.vld;
    assign out_result   = st_q.res;
    assign out_inexact  = st_q.inx;
    assign out_operr    = st_q.oper;
    assign stat_inexact = st_q.st_inx;
    assign stat_operr   = st_q.st_oper;

endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
    parameter int EXP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_class,
    input logic             in_sign,
    input logic [EXP_W-1:0] in_exp,
    input logic             flag_clr,
    input logic             out_valid,
    input logic [31:0]      out_result,
    input logic             out_inexact,
    input logic             out_operr,
    input logic             stat_inexact,
    input logic             stat_operr
);
    a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 3'd0 |=> out_result == 32'd0 && !out_inexact && !out_operr);

    a_r2_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 3'd1 |=> out_operr || out_result == 32'd0 || out_result[31] == $past(in_sign));

    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 3'd1 && in_exp[EXP_W-1] |=> out_result == 32'd0 && !out_operr);

    a_r5_big_exp: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 3'd1 && !in_exp[EXP_W-1] && in_exp[EXP_W-2:5] != '0 |=> out_operr);

    a_r7_specials: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class >= 3'd2 |=> out_operr);

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_operr |-> !out_inexact && (out_result == 32'h7FFF_FFFF || out_result == 32'h8000_0000));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_inexact) && $stable(out_operr));

    a_r10_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_inexact || stat_inexact) && (!out_operr || stat_operr));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !in_valid |=> !stat_inexact && !stat_operr);

    a_r10_persist: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr && stat_operr |=> stat_operr);

endmodule

bind f2i_trunc f2i_trunc_chk #(.EXP_W(EXP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .in_sign      (in_sign),
    .in_exp       (in_exp),
    .flag_clr     (flag_clr),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_inexact  (out_inexact),
    .out_operr    (out_operr),
    .stat_inexact (stat_inexact),
    .stat_operr   (stat_operr)
);

// File: tb/tb_f2i_trunc.sv
`timescale 1ns/1ps
module tb_f2i_trunc;
    localparam int MW = 40;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_class = 3'd0;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic          flag_clr = 1'b0;
    logic          out_valid;
    logic [31:0]   out_result;
    logic          out_inexact, out_operr, stat_inexact, stat_operr;

    int n_chk = 0;
    int n_bad = 0;
    logic m_sti = 1'b0;
    logic m_sto = 1'b0;

    always #2 clk = ~clk;

    f2i_trunc #(.MANT_W(MW), .EXP_W(EW)) dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // expected result from the requirement text
    function automatic logic [33:0] model(input logic [2:0] c, input logic s, input int e,
                                          input logic [MW-1:0] m, input logic st);
        logic [63:0] mag;
        logic [63:0] frac;
        logic        ovf;
        logic        inx;
        mag = 0; frac = 0; ovf = 0; inx = 0;
        if (c == 3'd0) return 34'd0;
        if (c != 3'd1) ovf = 1;
        else if (e >= 32) ovf = 1;
        else if (e < 0) inx = (m != 0) || st;
        else begin
            mag  = 64'(m) >> (MW - 1 - e);
            frac = 64'(m) & ((64'd1 << (MW - 1 - e)) - 1);
            inx  = (frac != 0) || st;
            if (mag >= 64'h8000_0000 + 64'(s)) ovf = 1;
        end
        if (ovf) return {1'b0, 1'b1, s ? 32'h8000_0000 : 32'h7FFF_FFFF};
        return {inx, 1'b0, s ? 32'(0 - mag[31:0]) : mag[31:0]};
    endfunction

    task automatic op(input logic [2:0] c, input logic s, input int e, input logic [MW-1:0] m,
                      input logic st, input logic clr, input string tag);
        logic [33:0] x;
        logic [31:0] held;
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = EW'(e);
        in_mant = m; in_sticky = st; flag_clr = clr;
        x = model(c, s, e, m, st);
        if (clr) begin m_sti = 0; m_sto = 0; end
        m_sti |= x[33]; m_sto |= x[32];
        @(negedge clk);
        chk(out_valid, {tag, " R9 valid"}, 32'(out_valid), 32'd1);
        chk(out_result == x[31:0], {tag, " result"}, out_result, x[31:0]);
        chk(out_inexact == x[33], {tag, " R4 inexact"}, 32'(out_inexact), 32'(x[33]));
        chk(out_operr == x[32], {tag, " R8 operr"}, 32'(out_operr), 32'(x[32]));
        chk(stat_inexact == m_sti && stat_operr == m_sto, {tag, " R10 status"},
            {30'd0, stat_inexact, stat_operr}, {30'd0, m_sti, m_sto});
        held = out_result;
        in_valid = 1'b0; flag_clr = 1'b0;
        in_class = 3'd2; in_exp = '0; in_mant = '1;
        @(negedge clk);
        chk(!out_valid && out_result == held && out_operr == x[32], {tag, " R9 idle hold"},
            out_result, held);
    endtask

    localparam logic [MW-1:0] ONE = MW'(1) << (MW - 1);

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2A_3C4D));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_result == 0 && !out_inexact && !out_operr
            && !stat_inexact && !stat_operr, "reset state", out_result, 32'd0);
        rst_n = 1'b1;

        op(3'd0, 1'b1, 5, ONE, 1'b1, 1'b0, "R1 negative zero");
        op(3'd1, 1'b0, 0, ONE, 1'b0, 1'b0, "R2 one");
        op(3'd1, 1'b1, 0, ONE | (ONE >> 1), 1'b0, 1'b0, "R2 R4 minus one point five");
        op(3'd1, 1'b0, 10, ONE | (ONE >> 10), 1'b1, 1'b0, "R4 sticky only");
        op(3'd1, 1'b0, -1, ONE, 1'b0, 1'b1, "R3 half");
        op(3'd1, 1'b1, -20, '0, 1'b0, 1'b0, "R3 exact tiny");
        op(3'd1, 1'b0, 31, ONE, 1'b0, 1'b0, "R6 plus 2^31");
        op(3'd1, 1'b1, 31, ONE, 1'b0, 1'b1, "R6 minus 2^31");
        op(3'd1, 1'b1, 31, ONE | 40'h1, 1'b0, 1'b0, "R6 minus 2^31 with fraction");
        op(3'd1, 1'b1, 31, ONE | 40'h100, 1'b0, 1'b0, "R6 below minus 2^31");
        op(3'd1, 1'b0, 30, '1, 1'b1, 1'b1, "R2 max positive");
        op(3'd1, 1'b0, 32, ONE, 1'b0, 1'b0, "R5 exp 32");
        op(3'd1, 1'b1, 300, ONE, 1'b0, 1'b1, "R5 huge exp");
        op(3'd2, 1'b1, 0, '0, 1'b0, 1'b0, "R7 minus inf");
        op(3'd3, 1'b0, 0, ONE, 1'b0, 1'b0, "R7 qnan");
        op(3'd4, 1'b1, 0, ONE, 1'b1, 1'b1, "R7 snan");
        op(3'd6, 1'b0, 3, ONE, 1'b0, 1'b0, "R7 unused code");

        for (int i = 0; i < 400; i++) begin
            logic [2:0]    c;
            int            e;
            int            r;
            logic [MW-1:0] m;
            r = int'($urandom % 16);
            case (r)
                0: c = 3'd0;
                1: c = 3'd2;
                2: c = 3'd3;
                3: c = 3'd4;
                4: c = 3'($urandom_range(5, 7));
                default: c = 3'd1;
            endcase
            e = int'($urandom_range(0, 46)) - 6;
            m = MW'({$urandom, $urandom});
            if ($urandom % 4 != 0) m[MW-1] = 1'b1;
            if (e >= 0 && e < 32 && $urandom % 3 == 0)
                m &= ~((MW'(1) << (MW - 1 - e)) - MW'(1));
            op(c, 1'($urandom), e, m, ($urandom % 4) == 0, ($urandom % 12) == 0, "R2 R4 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule